// File: doc/BRIEF.md
# Periodic Superstep Barrier Controller

This block paces a group of processing components through a chain of supersteps. Each component reports, with a one-cycle pulse, that its share of the current superstep is finished. The controller keeps a sticky flag per component and runs a period timer of programmable length L. The participation mask decides which flags count. When the flags allow it, the controller raises a one-cycle advance strobe to every component and bumps the superstep number. Otherwise the same superstep continues.

Two release policies are available at run time. In interval mode the barrier is looked at only in the last cycle of each L-cycle period. If the barrier is not met, a fresh full period is granted. In eager mode the barrier is looked at every cycle once at least L cycles of the superstep have elapsed. A superstep therefore lasts exactly L cycles when everyone finished early, and it ends as soon as the last flag arrives when someone finished late. A new L written on the input is only picked up when a period or superstep restarts, so a running interval is never cut short.

Top module: `superstep_barrier`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `superstep` is 0, `advance` is 0 and `done_flags` is 0. The first period after reset is DEFAULT_LEN cycles long, whatever `period_len` holds. So with a barrier that is already met, the first `advance` is seen in cycle DEFAULT_LEN after reset release, counting the first cycle as 1.
- R2: `advance` is high for one cycle per release. In that same cycle `superstep` has grown by exactly one, modulo 2^STEP_W. Outside such a cycle `superstep` does not change.
- R3: In interval mode (`eager_mode` = 0), a release happens only in the cycle after the last cycle of a period. It happens only if the barrier was met in that last cycle. If the barrier was not met, a further full L-cycle period starts, so releases are spaced by a whole number of periods.
- R4: The barrier is met when every component whose `sync_mask` bit is 1 has its flag set. A component whose mask bit is 0 never holds back a release. Its done pulse never triggers one either.
- R5: If `sync_mask` is all zeros, a release happens at every period end, so releases are exactly L cycles apart.
- R6: A `period_len` value takes effect only when a new period or superstep starts, so the running period keeps its length. The value 0 is taken as 1.
- R7: In eager mode (`eager_mode` = 1), the barrier is checked every cycle once L cycles of the superstep have passed. A release follows in the next cycle once the barrier is met. Releases are therefore never less than L cycles apart, and a late barrier is released one cycle after the last flag is set.
- R8: Bit i of `done_set` sets flag i, and the flag stays set until the next release. Every flag reads 0 in the cycle that `advance` is high. A pulse given in the last cycle before a release is discarded. A pulse given during the `advance` cycle counts toward the new superstep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| period_len | input | LEN_W | Period length L in cycles (0 means 1) |
| eager_mode | input | 1 | 0 = check at period ends, 1 = check every cycle after L cycles |
| sync_mask | input | N_COMP | 1 = component takes part in the barrier |
| done_set | input | N_COMP | One-cycle pulse per component marking its work finished |
| advance | output | 1 | One-cycle release strobe to all components |
| superstep | output | STEP_W | Current superstep number |
| done_flags | output | N_COMP | Sticky finished flags of the current superstep |

## Verification
The bench builds the block with four components, a 4-bit period length and a 4-bit superstep counter. The narrow superstep counter lets the random phase wrap the counter many times, which exercises the modulo step of R2. The narrow period field lets L sweep its whole range, including 0 and 1. DEFAULT_LEN is set to 5 while `period_len` is held at 3 during reset, so the reset-time length and the run-time length can be told apart. Four components are enough to build partial masks that separate a masked-out finisher from a participating one.

// File: rtl/sbar_pkg.sv
package sbar_pkg;

   // Release policy selected by the eager_mode pin
   typedef enum logic {
      SBAR_INTERVAL = 1'b0,
      SBAR_EAGER    = 1'b1
   } sbar_mode_e;

   // Shortest period the timer will run
   localparam int SBAR_MIN_LEN = 1;

endpackage

// File: rtl/sbar_period_timer.sv
module sbar_period_timer #(
   parameter int LEN_W       = 8,
   parameter int DEFAULT_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] len_in,
   input  logic             wrap,
   output logic             at_end
);
   import sbar_pkg::*;

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_next;

   // A zero length is raised to the minimum
   always_comb begin
      len_next = (len_in < LEN_W'(SBAR_MIN_LEN)) ? LEN_W'(SBAR_MIN_LEN) : len_in;
   end

   assign at_end = (cnt_q == len_q - LEN_W'(1));

   // Counter restarts on wrap and picks up the new length only then.
   // Without wrap it saturates on the last cycle (eager mode holds there).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= LEN_W'(DEFAULT_LEN);
      end else if (wrap) begin
         cnt_q <= '0;
         len_q <= len_next;
      end else if (!at_end) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   // R3: the position stays inside the running period
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) && (cnt_q < len_q));

   // R6: the latched length changes only across a restart
   assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wrap) |-> $stable(len_q));

endmodule

// File: rtl/sbar_done_tracker.sv
module sbar_done_tracker #(
   parameter int N_COMP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_COMP-1:0] set_in,
   input  logic [N_COMP-1:0] part_mask,
   input  logic              clear,
   output logic [N_COMP-1:0] flags,
   output logic              met
);
   logic [N_COMP-1:0] satisfied;

   for (genvar i = 0; i < N_COMP; i++) begin : g_slot
      logic flag_q;

      // A clear on the same edge wins over a new pulse
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (clear) begin
            flag_q <= 1'b0;
         end else if (set_in[i]) begin
            flag_q <= 1'b1;
         end
      end

      assign flags[i]     = flag_q;
      assign satisfied[i] = flag_q | ~part_mask[i];
   end

   assign met = &satisfied;

endmodule

// File: rtl/superstep_barrier.sv
module superstep_barrier #(
   parameter int N_COMP      = 4,
   parameter int LEN_W       = 8,
   parameter int STEP_W      = 16,
   parameter int DEFAULT_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  period_len,
   input  logic              eager_mode,
   input  logic [N_COMP-1:0] sync_mask,
   input  logic [N_COMP-1:0] done_set,
   output logic              advance,
   output logic [STEP_W-1:0] superstep,
   output logic [N_COMP-1:0] done_flags
);
   import sbar_pkg::*;

   localparam longint LEN_LIMIT = longint'(1) << LEN_W;

   // Elaboration-time parameter checks
   if (N_COMP < 1) begin : g_bad_ncomp
      $error("superstep_barrier: N_COMP must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > 31) begin : g_bad_lenw
      $error("superstep_barrier: LEN_W must be in 1..31");
   end
   if (STEP_W < 1) begin : g_bad_stepw
      $error("superstep_barrier: STEP_W must be at least 1");
   end
   if (DEFAULT_LEN < SBAR_MIN_LEN || longint'(DEFAULT_LEN) >= LEN_LIMIT) begin : g_bad_deflen
      $error("superstep_barrier: DEFAULT_LEN must be >= 1 and fit in LEN_W bits");
   end

   sbar_mode_e        mode;
   logic              at_end;
   logic              met;
   logic              fire;
   logic              wrap;
   logic              adv_q;
   logic [STEP_W-1:0] step_q;

   assign mode = sbar_mode_e'(eager_mode);
   assign fire = at_end & met;
   assign wrap = (mode == SBAR_EAGER) ? fire : at_end;

   sbar_period_timer #(
      .LEN_W      (LEN_W),
      .DEFAULT_LEN(DEFAULT_LEN)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .len_in(period_len),
      .wrap  (wrap),
      .at_end(at_end)
   );

   sbar_done_tracker #(
      .N_COMP(N_COMP)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_in   (done_set),
      .part_mask(sync_mask),
      .clear    (fire),
      .flags    (done_flags),
      .met      (met)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adv_q  <= 1'b0;
         step_q <= '0;
      end else begin
         adv_q <= fire;
         if (fire) begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   assign advance   = adv_q;
   assign superstep = step_q;

   // R2: each release bumps the superstep number by one
   assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> superstep == $past(superstep) + STEP_W'(1));

   // R2: no release, no change
   assert_step_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |-> $stable(superstep));

   // R4: a release needs every participating flag set a cycle earlier
   assert_adv_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> $past(&(done_flags | ~sync_mask)));

   // R8: flags start empty in the release cycle
   assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> done_flags == '0);

endmodule

// File: tb/tb_superstep_barrier.sv
module tb_superstep_barrier;
   localparam int N      = 4;
   localparam int LW     = 4;
   localparam int SW     = 4;
   localparam int DEFLEN = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LW-1:0] period_len;
   logic          eager_mode;
   logic [N-1:0]  sync_mask;
   logic [N-1:0]  done_set;
   logic          advance;
   logic [SW-1:0] superstep;
   logic [N-1:0]  done_flags;

   int  errors = 0;
   int  checks = 0;
   bit  finished = 0;

   always #10 clk = ~clk;

   superstep_barrier #(
      .N_COMP(N), .LEN_W(LW), .STEP_W(SW), .DEFAULT_LEN(DEFLEN)
   ) dut (
      .clk(clk), .rst_n(rst_n), .period_len(period_len), .eager_mode(eager_mode),
      .sync_mask(sync_mask), .done_set(done_set), .advance(advance),
      .superstep(superstep), .done_flags(done_flags)
   );

   // ---------------- expected-value functions and cycle model ----------------
   function automatic logic [LW-1:0] eff_len(input logic [LW-1:0] l);
      return (l == '0) ? LW'(1) : l;
   endfunction

   function automatic logic barrier_met(input logic [N-1:0] f, input logic [N-1:0] m);
      return &(f | ~m);
   endfunction

   logic [LW-1:0] m_cnt, m_len;
   logic [N-1:0]  m_flags;
   logic [SW-1:0] m_step;
   logic          m_adv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_len <= LW'(DEFLEN); m_flags <= '0; m_step <= '0; m_adv <= 1'b0;
      end else begin
         logic last, rel, restart;
         last    = (m_cnt == m_len - LW'(1));
         rel     = last && barrier_met(m_flags, sync_mask);
         restart = eager_mode ? rel : last;
         m_cnt   <= restart ? '0 : (last ? m_cnt : m_cnt + LW'(1));
         m_len   <= restart ? eff_len(period_len) : m_len;
         m_flags <= rel ? '0 : (m_flags | done_set);
         m_step  <= m_step + SW'(rel);
         m_adv   <= rel;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      chk(advance == m_adv, "R2", "advance", int'(advance), int'(m_adv));
      chk(superstep == m_step, "R2", "superstep", int'(superstep), int'(m_step));
      chk(done_flags == m_flags, "R8", "done_flags", int'(done_flags), int'(m_flags));
   endtask

   // Runs until advance is seen; pulses done_set with pval after negedge pulse_at
   // (pulse_at 0 means during the current cycle). n counts negedges.
   task automatic run_adv(input int pulse_at, input logic [N-1:0] pval, input int limit,
                          output int n, output bit found);
      found = 0;
      n = 0;
      done_set = (pulse_at == 0) ? pval : '0;
      for (int k = 1; k <= limit; k++) begin
         tick();
         n = k;
         if (advance) begin
            found = 1;
            done_set = '0;
            break;
         end
         done_set = (k == pulse_at) ? pval : '0;
      end
      if (!found) begin
         done_set = '0;
         n = limit + 1;
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(20 * 60000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int n;
      bit f;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; period_len = LW'(3); eager_mode = 1'b0; sync_mask = '0; done_set = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(superstep == '0, "R1", "reset superstep", int'(superstep), 0);
      chk(advance == 1'b0, "R1", "reset advance", int'(advance), 0);
      chk(done_flags == '0, "R1", "reset done_flags", int'(done_flags), 0);
      rst_n = 1'b1;

      // R1: first period uses DEFAULT_LEN; R5: empty mask releases each period
      run_adv(-1, '0, 20, n, f);
      chk(n == DEFLEN, "R1", "first release cycle", n, DEFLEN);
      run_adv(-1, '0, 20, n, f);
      chk(n == 3, "R5", "release gap with empty mask", n, 3);
      chk(superstep == SW'(2), "R2", "superstep after two releases", int'(superstep), 2);

      // R3: unmet barrier gets whole extra periods
      period_len = LW'(4);
      run_adv(-1, '0, 20, n, f);
      chk(n == 3, "R6", "running period kept its length", n, 3);
      sync_mask = 4'hF;
      run_adv(13, 4'hF, 30, n, f);
      chk(n == 16, "R3", "release at next period end", n, 16);

      // R4: partial mask
      sync_mask = 4'b0101;
      run_adv(2, 4'b0101, 30, n, f);
      chk(n == 4, "R4", "participants only", n, 4);
      run_adv(1, 4'b1010, 10, n, f);
      chk(f == 1'b0, "R4", "masked-out finishers ignored", int'(f), 0);
      chk(done_flags == 4'b1010, "R8", "flags sticky", int'(done_flags), 10);

      // R6: new L at the next boundary, 0 as 1
      sync_mask = '0;
      run_adv(-1, '0, 20, n, f);
      period_len = LW'(7);
      run_adv(-1, '0, 20, n, f);
      chk(n == 4, "R6", "old length finishes", n, 4);
      run_adv(-1, '0, 20, n, f);
      chk(n == 7, "R6", "new length in force", n, 7);
      period_len = '0;
      run_adv(-1, '0, 20, n, f);
      chk(n == 7, "R6", "zero length deferred", n, 7);
      run_adv(-1, '0, 20, n, f);
      chk(n == 1, "R6", "zero length as one", n, 1);
      run_adv(-1, '0, 20, n, f);
      chk(n == 1, "R6", "zero length as one again", n, 1);

      // R7: eager mode
      sync_mask = 4'hF; period_len = LW'(6); eager_mode = 1'b1;
      run_adv(2, 4'hF, 20, n, f);
      chk(n == 4, "R7", "eager release after flags", n, 4);
      run_adv(1, 4'hF, 20, n, f);
      chk(n == 6, "R7", "eager minimum length", n, 6);
      chk(done_flags == '0, "R8", "flags empty at release", int'(done_flags), 0);
      run_adv(9, 4'hF, 30, n, f);
      chk(n == 11, "R7", "eager late release", n, 11);

      // R8: clear timing
      eager_mode = 1'b0; period_len = LW'(4);
      run_adv(3, 4'hF, 30, n, f);
      chk(n == 6, "R3", "interval release at period end", n, 6);
      run_adv(0, 4'hF, 20, n, f);
      chk(n == 4, "R8", "pulse in advance cycle counts", n, 4);
      sync_mask = '0;
      run_adv(3, 4'hF, 20, n, f);
      chk(n == 4, "R5", "empty mask gap", n, 4);
      chk(done_flags == '0, "R8", "pulse before release dropped", int'(done_flags), 0);
      sync_mask = 4'hF;
      run_adv(-1, '0, 10, n, f);
      chk(f == 1'b0, "R8", "no stale flag releases", int'(f), 0);

      // Random phase against the cycle model (R2 wrap, R3, R4, R7, R8)
      for (int c = 0; c < 3000; c++) begin
         tick();
         if ($urandom_range(39, 0) == 0) period_len = LW'($urandom_range(8, 0));
         if ($urandom_range(59, 0) == 0) eager_mode = ~eager_mode;
         if ($urandom_range(49, 0) == 0) sync_mask = N'($urandom());
         for (int b = 0; b < N; b++) done_set[b] = ($urandom_range(5, 0) == 0);
      end
      done_set = '0;
      tick();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule